// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block captures requests on eight edge-sensitive interrupt lines and decides, every cycle, whether one of them should be presented to the processor and which one. Each line keeps its previous level. A low-to-high transition latches a pending request bit. The pending set, less the masked lines, is compared against the set of lines already in service. Both comparisons use a rotating priority order: a 3-bit rotation offset names the line that currently holds the top priority.

The surrounding controller supplies the mask, the rotation offset load, the auto end-of-interrupt options, the nesting option and a specific end-of-interrupt strobe as plain inputs. When the processor acknowledges, the block takes the line it is presenting at that moment and clears that line's pending bit. It then either marks the line as in service or, in auto end-of-interrupt mode, leaves the in-service set alone and can rotate the priority so that the acknowledged line becomes the lowest.

Top module: `rot_prio_resolver`

## Requirements
- R1: While rst_n is low, int_valid and int_line are 0, and the pending, in-service and previous-level state is cleared with the rotation offset at 0. No request is presented after release until a line rises.
- R2: A pending bit is set only when its line is seen at 1 after having been 0 on the previous clock. A line held high or falling sets nothing.
- R3: Priority level p belongs to line (p + offset) mod 8, and level 0 is the highest. The presented line is the candidate with the best level.
- R4: Candidates are the pending bits whose mask_in bit is 0. A masked pending request is not presented, but it stays pending and appears once unmasked.
- R5: A candidate is presented only if its level is strictly better than the best in-service level. An equal or worse level presents nothing.
- R6: With sfnm_en and is_master both 1, in-service bit 2 is left out of the in-service comparison. Otherwise it counts.
- R7: ack while int_valid is 1 clears the pending bit of int_line. With auto_eoi at 0 it also sets that line's in-service bit. ack while int_valid is 0 changes nothing.
- R8: With auto_eoi at 1, an acknowledge sets no in-service bit. If rotate_aeoi is also 1, the offset becomes (acknowledged line + 1) mod 8.
- R9: offset_load copies offset_in into the offset. When it coincides with an auto-EOI rotation, the load wins.
- R10: eoi clears the in-service bit named by eoi_line. When eoi and the acknowledge's in-service set coincide, the set is applied after the clear.
- R11: int_valid and int_line are registered. They reflect the state and inputs of the previous cycle. int_line is 0 whenever int_valid is 0.
- R12: A new rising edge on the line being acknowledged in the same cycle leaves that line pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt line levels |
| mask_in | input | 8 | Per-line mask, 1 blocks the line |
| offset_load | input | 1 | Load offset_in into the rotation offset |
| offset_in | input | 3 | New rotation offset |
| auto_eoi | input | 1 | Auto end-of-interrupt on acknowledge |
| rotate_aeoi | input | 1 | Rotate priority on auto end-of-interrupt |
| sfnm_en | input | 1 | Nesting option that ignores in-service line 2 |
| is_master | input | 1 | This instance is the master of a cascade |
| ack | input | 1 | Processor acknowledge of the presented line |
| eoi | input | 1 | Specific end-of-interrupt strobe |
| eoi_line | input | 3 | Line whose in-service bit eoi clears |
| int_valid | output | 1 | An interrupt is presented |
| int_line | output | 3 | Presented line |

## Verification
The assertions check on every cycle that pending bits appear only after a rising edge and that in-service bits appear only one at a time, through an acknowledge outside auto end-of-interrupt mode. They also check that the offset moves only through a load or an auto-EOI rotation, and that a presented line was an unmasked pending request that was not in service. Only the bench scenarios can show the exact choice of line under a rotated order, the strict-priority blocking and the nesting exception on line 2. The same holds for the collision rules between acknowledge, new edges, end-of-interrupt and offset load. The bench checks these against a cycle model over long random runs and directed sequences.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_SERVICE = 2'd1,
    ACT_AEOI    = 2'd2,
    ACT_AEOI_RT = 2'd3
  } ack_action_e;

endpackage

// File: rtl/rpr_prio_search.sv
module rpr_prio_search #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] off,
  output logic [W:0]   level
);

  logic [N-1:0] rot;

  // rot[p] is the line that holds priority level p
  for (genvar gp = 0; gp < N; gp++) begin : g_rot
    logic [W-1:0] src;
    assign src     = W'(gp) + off;
    assign rot[gp] = vec[src];
  end

  always_comb begin
    level = (W+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot[p]) level = (W+1)'(p);
    end
  end

endmodule

// File: rtl/rpr_edge_capture.sv
module rpr_edge_capture #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic         clr_en,
  input  logic [W-1:0] clr_idx,
  output logic [N-1:0] req_q
);

  logic [N-1:0] prev_q;
  logic [N-1:0] req_d;
  logic [N-1:0] rise;

  assign rise = lines & ~prev_q;

  always_comb begin
    req_d = req_q;
    if (clr_en) req_d[clr_idx] = 1'b0;
    req_d = req_d | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      prev_q <= '0;
    end else begin
      req_q  <= req_d;
      prev_q <= lines;
    end
  end

  // R2: a pending bit only appears after a rising edge on its line
  a_r2_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~$past(req_q)) & ~$past(lines & ~prev_q)) == '0);

endmodule

// File: rtl/rpr_service.sv
module rpr_service
  import rpr_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ack_fire,
  input  logic [W-1:0] ack_idx,
  input  logic         auto_eoi,
  input  logic         rotate_aeoi,
  input  logic         eoi,
  input  logic [W-1:0] eoi_line,
  input  logic         off_load,
  input  logic [W-1:0] off_in,
  output logic [N-1:0] isr_q,
  output logic [W-1:0] off_q
);

  ack_action_e  act;
  logic [N-1:0] isr_d;
  logic [W-1:0] off_d;
  logic         off_en;

  always_comb begin
    if (!ack_fire)        act = ACT_NONE;
    else if (!auto_eoi)   act = ACT_SERVICE;
    else if (rotate_aeoi) act = ACT_AEOI_RT;
    else                  act = ACT_AEOI;
  end

  always_comb begin
    isr_d = isr_q;
    if (eoi) isr_d[eoi_line] = 1'b0;
    if (act == ACT_SERVICE) isr_d[ack_idx] = 1'b1;
  end

  always_comb begin
    off_en = off_load || (act == ACT_AEOI_RT);
    off_d  = off_load ? off_in : ack_idx + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      off_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (off_en) off_q <= off_d;
    end
  end

  // R7: in-service bits appear one at a time, only through a normal acknowledge
  a_r7_isr_set_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q & ~$past(isr_q)) != '0 |-> $past(ack_fire && !auto_eoi));
  a_r7_isr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_q & ~$past(isr_q)));
  // R8 / R9: offset moves only via a load or an auto-EOI rotation
  a_r8_offset_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off_q) |-> $past(off_load || (ack_fire && auto_eoi && rotate_aeoi)));

endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int unsigned N        = 8,
  parameter int unsigned CASC_BIT = 2,
  localparam int unsigned W       = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] mask_in,
  input  logic         offset_load,
  input  logic [W-1:0] offset_in,
  input  logic         auto_eoi,
  input  logic         rotate_aeoi,
  input  logic         sfnm_en,
  input  logic         is_master,
  input  logic         ack,
  input  logic         eoi,
  input  logic [W-1:0] eoi_line,
  output logic         int_valid,
  output logic [W-1:0] int_line
);

  logic [N-1:0] req_q;
  logic [N-1:0] isr_q;
  logic [W-1:0] off_q;
  logic [N-1:0] cand;
  logic [N-1:0] isr_eff;
  logic [N-1:0] casc_mask;
  logic [W:0]   cand_lvl;
  logic [W:0]   cur_lvl;
  logic         ack_fire;
  logic         present;
  logic [W-1:0] line_d;

  assign ack_fire  = ack && int_valid;
  assign casc_mask = (sfnm_en && is_master) ? (N'(1) << CASC_BIT) : '0;
  assign cand      = req_q & ~mask_in;
  assign isr_eff   = isr_q & ~casc_mask;

  rpr_edge_capture #(.N(N)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (irq_in),
    .clr_en  (ack_fire),
    .clr_idx (int_line),
    .req_q   (req_q)
  );

  rpr_service #(.N(N)) u_svc (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_fire    (ack_fire),
    .ack_idx     (int_line),
    .auto_eoi    (auto_eoi),
    .rotate_aeoi (rotate_aeoi),
    .eoi         (eoi),
    .eoi_line    (eoi_line),
    .off_load    (offset_load),
    .off_in      (offset_in),
    .isr_q       (isr_q),
    .off_q       (off_q)
  );

  rpr_prio_search #(.N(N)) u_cand (
    .vec   (cand),
    .off   (off_q),
    .level (cand_lvl)
  );

  rpr_prio_search #(.N(N)) u_cur (
    .vec   (isr_eff),
    .off   (off_q),
    .level (cur_lvl)
  );

  always_comb begin
    present = cand_lvl < cur_lvl;
    line_d  = present ? (cand_lvl[W-1:0] + off_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_valid <= 1'b0;
      int_line  <= '0;
    end else begin
      int_valid <= present;
      int_line  <= line_d;
    end
  end

  // R4: a presented line was an unmasked pending request one cycle earlier
  a_r4_presented_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> |(($past(cand) >> int_line) & N'(1)));
  // R5: a presented line was not already counted as in service
  a_r5_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> (($past(isr_eff) >> int_line) & N'(1)) == '0);
  // R11: the line field is zero whenever nothing is presented
  a_r11_line_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !int_valid |-> int_line == '0);

endmodule

// File: tb/tb_rot_prio_resolver.sv
`timescale 1ns/1ps
module tb_rot_prio_resolver;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in, mask_in;
  logic       offset_load, auto_eoi, rotate_aeoi, sfnm_en, is_master, ack, eoi;
  logic [2:0] offset_in, eoi_line;
  logic       int_valid;
  logic [2:0] int_line;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model state
  logic [7:0] m_irr, m_isr, m_prev;
  logic [2:0] m_off;
  logic       m_v;
  logic [2:0] m_l;

  always #2.5 clk = ~clk;

  rot_prio_resolver dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_in(mask_in),
    .offset_load(offset_load), .offset_in(offset_in), .auto_eoi(auto_eoi),
    .rotate_aeoi(rotate_aeoi), .sfnm_en(sfnm_en), .is_master(is_master),
    .ack(ack), .eoi(eoi), .eoi_line(eoi_line),
    .int_valid(int_valid), .int_line(int_line)
  );

  function automatic int search(logic [7:0] v, logic [2:0] off);
    for (int p = 0; p < 8; p++) begin
      logic [2:0] ln;
      ln = 3'(p) + off;
      if (v[ln]) return p;
    end
    return 8;
  endfunction

  task automatic check(string tag, logic v, logic [2:0] l);
    total++;
    if (int_valid !== v || int_line !== l) begin
      bad++;
      $display("FAIL %s: actual valid=%0b line=%0d expected valid=%0b line=%0d",
               tag, int_valid, int_line, v, l);
    end
  endtask

  // advance one clock, update model, compare outputs after the edge
  task automatic step(string tag);
    int cl, cu;
    logic [7:0] ie;
    logic nv;
    logic [2:0] nl, n;
    logic af;
    cl = search(m_irr & ~mask_in, m_off);
    ie = m_isr & ~((sfnm_en && is_master) ? 8'h04 : 8'h00);
    cu = search(ie, m_off);
    nv = cl < cu;
    nl = nv ? 3'(cl) + m_off : 3'd0;
    af = ack && m_v;
    n  = m_l;
    @(posedge clk);
    #1;
    if (af) m_irr[n] = 1'b0;
    m_irr  = m_irr | (irq_in & ~m_prev);
    m_prev = irq_in;
    if (eoi) m_isr[eoi_line] = 1'b0;
    if (af && !auto_eoi) m_isr[n] = 1'b1;
    if (offset_load) m_off = offset_in;
    else if (af && auto_eoi && rotate_aeoi) m_off = n + 3'd1;
    m_v = nv;
    m_l = nl;
    check(tag, m_v, m_l);
  endtask

  task automatic idle_inputs();
    irq_in = 8'h00; mask_in = 8'h00; offset_load = 0; offset_in = 0;
    auto_eoi = 0; rotate_aeoi = 0; sfnm_en = 0; is_master = 0;
    ack = 0; eoi = 0; eoi_line = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_inputs();
    rst_n = 0;
    m_irr = 0; m_isr = 0; m_prev = 0; m_off = 0; m_v = 0; m_l = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 1'b0, 3'd0);
    irq_in = 8'hff;
    @(posedge clk); #1;
    check("R1 lines ignored in reset", 1'b0, 3'd0);
    irq_in = 8'h00;
    rst_n = 1;
    step("R1 after release");
    step("R1 idle");

    // R2: rising edge, held level, falling edge
    irq_in = 8'h10; step("R2 rise captured");
    step("R2 presented line 4");
    ack = 1; step("R7 ack line 4"); ack = 0;
    step("R2 held high no new request");
    step("R5 in-service blocks nothing pending");
    irq_in = 8'h00; step("R2 fall sets nothing");
    step("R2 idle after fall");
    eoi = 1; eoi_line = 3'd4; step("R10 clear line 4"); eoi = 0;
    step("R10 idle");

    // R3: rotation offset picks the order
    offset_load = 1; offset_in = 3'd5; step("R9 load offset 5"); offset_load = 0;
    irq_in = 8'h41; step("R3 lines 0 and 6 rise");
    step("R3 line 6 wins with offset 5");
    irq_in = 8'h00; mask_in = 8'h40; step("R4 mask line 6");
    step("R4 line 0 shown while 6 masked");
    mask_in = 8'hff; step("R4 all masked");
    step("R4 nothing presented");
    mask_in = 8'h00; step("R4 unmask");
    step("R4 pending line 6 returns");

    // R5: in-service equal and better levels block
    ack = 1; step("R7 service line 6"); ack = 0;
    step("R5 line 0 lower than in-service 6");
    step("R5 still blocked");
    offset_load = 1; offset_in = 3'd0; step("R9 offset 0"); offset_load = 0;
    step("R5 line 0 now beats line 6");
    ack = 1; step("R7 service line 0"); ack = 0;
    step("R5 none pending");
    // R6: line 2 in service under nesting option
    irq_in = 8'h02; step("R6 line 1 rises");
    step("R6 line 1 blocked by in-service 0");
    eoi = 1; eoi_line = 3'd0; step("R10 clear 0"); eoi = 0;
    step("R6 line 1 presented");
    ack = 1; step("R6 service line 1"); ack = 0; irq_in = 8'h00;
    eoi = 1; eoi_line = 3'd6; step("R10 clear 6"); eoi = 0;
    irq_in = 8'h08; step("R6 line 3 rises");
    step("R6 line 3 blocked by line 1");
    eoi = 1; eoi_line = 3'd1; step("R10 clear 1"); eoi = 0;
    irq_in = 8'h04; step("R6 line 2 rises");
    step("R6 line 2 presented");
    ack = 1; step("R6 service line 2"); ack = 0; irq_in = 8'h00;
    step("R6 line 3 blocked by in-service 2");
    sfnm_en = 1; is_master = 1; step("R6 nesting on master");
    step("R6 line 3 now presented");
    is_master = 0; step("R6 not master counts line 2");
    step("R6 blocked again");
    sfnm_en = 0; eoi = 1; eoi_line = 3'd2; step("R10 clear 2"); eoi = 0;

    // R8: auto-EOI with rotation
    step("R8 line 3 presented");
    auto_eoi = 1; rotate_aeoi = 1; ack = 1; step("R8 aeoi ack line 3"); ack = 0;
    irq_in = 8'h11; step("R8 lines 0 and 4 rise");
    step("R8 line 4 first with offset 4");
    ack = 1; offset_load = 1; offset_in = 3'd0;
    step("R9 load beats rotation"); ack = 0; offset_load = 0;
    step("R9 line 0 first with offset 0");
    // R12: ack and new edge on same line
    irq_in = 8'h00; step("R12 drop lines");
    step("R12 line 0 still pending");
    irq_in = 8'h01; ack = 1; step("R12 ack with new rise"); ack = 0;
    step("R12 line 0 stays pending");
    ack = 1; step("R12 ack again"); ack = 0;
    auto_eoi = 0; rotate_aeoi = 0; irq_in = 8'h00;
    step("R11 settle");
    step("R11 settle");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      irq_in      = 8'($urandom);
      mask_in     = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      offset_load = (($urandom % 20) == 0);
      offset_in   = 3'($urandom);
      auto_eoi    = (($urandom % 3) == 0);
      rotate_aeoi = 1'($urandom);
      sfnm_en     = 1'($urandom);
      is_master   = 1'($urandom);
      ack         = (($urandom % 3) == 0);
      eoi         = (($urandom % 4) == 0);
      eoi_line    = 3'($urandom);
      step("R3 R5 R7 R8 R11 random");
    end

    idle_inputs();
    rst_n = 0;
    #1;
    check("R1 async reset", 1'b0, 3'd0);
    m_irr = 0; m_isr = 0; m_prev = 0; m_off = 0; m_v = 0; m_l = 0;
    @(posedge clk); #1;
    rst_n = 1;
    step("R1 after second reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule